// File: doc/BRIEF.md
# Infrared Receive Data Gate

This block sits between an infrared pulse detector and the serial receive pin that a host UART reads. While the local transmitter has its LEDs lit, the block can hold the receive line at its idle (high) level. The host then does not read back its own transmission as an echo. The hold is not released the moment the LEDs go dark. A holdoff of a fixed duration follows, counted in ticks of a timebase, and it starts over if the LEDs light again before it runs out. A control input turns this blanking on or off; with blanking off, detected data reaches the pin even during transmission.

For television-remote style reception there is a wait-for-signal option. With it active, the output stays high after the receiver is enabled until the detector reports the first valid infrared signal. From then on detected data passes until the receiver is disabled. Disabling the receiver re-arms the wait, so each new enable waits for a signal again. A free-run control bit skips the wait, and the output follows the data at once.

The holdoff length is derived at elaboration from a clock rate and a duration in nanoseconds. The defaults are a 7.3728 MHz timebase and 8000 ns, which gives 59 ticks. The output is registered.

Top module: `irrx_gate`

## Requirements
- R1: In reset and on the first edge after reset, `rxd` is 1 and the wait-for-signal latch is clear: with `tv_mode`=1 and `hes_free`=0, `rxd` stays 1 until `sig_valid` is seen.
- R2: When `rx_en` is 0 at a clock edge, `rxd` is 1 after that edge, whatever the other inputs are. Dropping `rx_en` also clears the wait-for-signal latch.
- R3: When `blank_en` is 1 and `led_on` is 1 at an edge, `rxd` is 1 after that edge.
- R4: After `led_on` falls with `blank_en`=1, `rxd` stays 1 until HOLD_TICKS edges with `tick`=1 have been sampled. Data passes from the next edge on. Edges with `tick`=0 do not advance the holdoff.
- R5: If `led_on` rises again during the holdoff, the full HOLD_TICKS holdoff starts over once it falls again.
- R6: When `blank_en` is 0, `rx_raw` reaches `rxd` during `led_on` and during any holdoff still in progress. If `blank_en` returns to 1 before the holdoff ends, blanking resumes for the rest of it.
- R7: With `tv_mode`=1 and `hes_free`=0, `rxd` is 1 after each enabled edge until an edge with `sig_valid`=1. The data of that same edge already passes.
- R8: Once a valid signal has been seen, data keeps passing while `rx_en` stays 1, even when `sig_valid` is 0.
- R9: With `tv_mode`=0, or with `hes_free`=1, data passes as soon as the receiver is enabled, without any `sig_valid`.
- R10: The latency is one register. `rxd` after edge k equals `rx_raw` sampled at edge k whenever data passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Timebase enable that advances the holdoff |
| led_on | input | 1 | High while the transmit LEDs are lit |
| rx_raw | input | 1 | Detected serial data from the pulse detector |
| sig_valid | input | 1 | Strobe for a valid infrared signal |
| rx_en | input | 1 | Receiver enable |
| blank_en | input | 1 | Enables output blanking during transmission (0 after reset at the register bank) |
| tv_mode | input | 1 | Selects television-remote reception |
| hes_free | input | 1 | 1 skips the wait for the first valid signal (0 after reset at the register bank) |
| rxd | output | 1 | Registered receive data to the UART; idle high |

## Verification
The bench counts the blanked cycles after `led_on` falls, edge by edge. A holdoff one tick short or one tick long shows up as a 0 or 1 at the wrong edge. It re-lights the LEDs partway through the holdoff; a counter that is not reloaded releases too early. It holds `tick` low for long stretches to catch a holdoff that counts clock cycles instead of ticks. It sweeps every combination of blanking, TV mode and free-run with a disable and re-enable in each. A latch that is not re-armed lets data out before `sig_valid`. A latch that drops early turns data back to idle.

// File: rtl/irrx_gate_pkg.sv
package irrx_gate_pkg;

  // Output source chosen for the next rxd value, in priority order.
  typedef enum logic [1:0] {
    SEL_OFF   = 2'd0,  // receiver disabled
    SEL_BLANK = 2'd1,  // transmit blanking or holdoff
    SEL_WAIT  = 2'd2,  // waiting for first valid signal
    SEL_DATA  = 2'd3   // pass detected data
  } rx_sel_e;

  localparam logic RX_IDLE = 1'b1;

  // Number of timebase ticks covering a delay, rounded up.
  function automatic int ticks_for(longint unsigned delay_ns, longint unsigned clk_hz);
    longint unsigned prod;
    prod = delay_ns * clk_hz;
    return int'((prod + 64'd999_999_999) / 64'd1_000_000_000);
  endfunction

endpackage

// File: rtl/irrx_holdoff.sv
module irrx_holdoff #(
  parameter int HOLD_TICKS = 59
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic led_on,
  output logic busy
);
  localparam int CW = $clog2(HOLD_TICKS + 1);
  localparam logic [CW-1:0] LOAD = CW'(HOLD_TICKS);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (led_on) begin
      cnt_q <= LOAD;
    end else if (tick && (cnt_q != '0)) begin
      cnt_q <= cnt_q - CW'(1);
    end
  end

  assign busy = led_on | (cnt_q != '0);

  // R5: lit LEDs always leave the full holdoff pending
  a_r5_reload: assert property (@(posedge clk) disable iff (rst)
    led_on |=> (cnt_q == LOAD));
  // R4: one tick removes exactly one step
  a_r4_step: assert property (@(posedge clk) disable iff (rst)
    (!led_on && tick && (cnt_q != '0)) |=> (cnt_q == $past(cnt_q) - CW'(1)));
  // R4: no tick, no progress
  a_r4_freeze: assert property (@(posedge clk) disable iff (rst)
    (!led_on && !tick) |=> $stable(cnt_q));
endmodule

// File: rtl/irrx_hesitate.sv
module irrx_hesitate (
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic sig_valid,
  output logic go
);
  logic seen_q;

  always_ff @(posedge clk) begin
    if (rst || !rx_en) begin
      seen_q <= 1'b0;
    end else if (sig_valid) begin
      seen_q <= 1'b1;
    end
  end

  // The strobe cycle itself already counts as seen.
  assign go = seen_q | sig_valid;

  // R8: latch stays set while the receiver stays enabled
  a_r8_sticky: assert property (@(posedge clk) disable iff (rst)
    (seen_q && rx_en) |=> seen_q);
  // R2: disabling re-arms the wait
  a_r2_rearm: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> !seen_q);
endmodule

// File: rtl/irrx_outsel.sv
module irrx_outsel
  import irrx_gate_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rx_en,
  input  logic blank_en,
  input  logic busy,
  input  logic tv_mode,
  input  logic hes_free,
  input  logic go,
  input  logic rx_raw,
  output logic rxd
);
  rx_sel_e sel;
  logic    rxd_q;

  always_comb begin
    if (!rx_en)                          sel = SEL_OFF;
    else if (blank_en && busy)           sel = SEL_BLANK;
    else if (tv_mode && !hes_free && !go) sel = SEL_WAIT;
    else                                 sel = SEL_DATA;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rxd_q <= RX_IDLE;
    end else begin
      rxd_q <= (sel == SEL_DATA) ? rx_raw : RX_IDLE;
    end
  end

  assign rxd = rxd_q;
endmodule

// File: rtl/irrx_gate.sv
module irrx_gate
  import irrx_gate_pkg::*;
#(
  parameter longint unsigned CLK_HZ  = 64'd7_372_800,
  parameter longint unsigned HOLD_NS = 64'd8000
) (
  input  logic clk,
  input  logic rst,
  input  logic tick,
  input  logic led_on,
  input  logic rx_raw,
  input  logic sig_valid,
  input  logic rx_en,
  input  logic blank_en,
  input  logic tv_mode,
  input  logic hes_free,
  output logic rxd
);
  localparam int HOLD_TICKS = ticks_for(HOLD_NS, CLK_HZ);

  logic busy;
  logic go;

  irrx_holdoff #(.HOLD_TICKS(HOLD_TICKS)) u_holdoff (
    .clk    (clk),
    .rst    (rst),
    .tick   (tick),
    .led_on (led_on),
    .busy   (busy)
  );

  irrx_hesitate u_hesitate (
    .clk       (clk),
    .rst       (rst),
    .rx_en     (rx_en),
    .sig_valid (sig_valid),
    .go        (go)
  );

  irrx_outsel u_outsel (
    .clk      (clk),
    .rst      (rst),
    .rx_en    (rx_en),
    .blank_en (blank_en),
    .busy     (busy),
    .tv_mode  (tv_mode),
    .hes_free (hes_free),
    .go       (go),
    .rx_raw   (rx_raw),
    .rxd      (rxd)
  );

  initial begin
    a_r4_len: assert (HOLD_TICKS >= 1);
  end

  // R2: disabled receiver idles high
  a_r2_off: assert property (@(posedge clk) disable iff (rst)
    !rx_en |=> rxd);
  // R3: lit LEDs with blanking give idle
  a_r3_blank: assert property (@(posedge clk) disable iff (rst)
    (blank_en && led_on) |=> rxd);
  // R7: waiting receiver idles high
  a_r7_wait: assert property (@(posedge clk) disable iff (rst)
    (rx_en && tv_mode && !hes_free && !go) |=> rxd);
  // R6/R10: without blanking and without waiting, data passes one cycle later
  a_r6_pass: assert property (@(posedge clk) disable iff (rst)
    (rx_en && !blank_en && (!tv_mode || hes_free)) |=> (rxd == $past(rx_raw)));
endmodule

// File: tb/irrx_gate_bench.sv
module irrx_gate_bench;
  localparam longint unsigned T_HZ = 64'd1_000_000;
  localparam longint unsigned T_NS = 64'd5000;
  localparam int H = int'((T_NS * T_HZ + 64'd999_999_999) / 64'd1_000_000_000);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b1, led_on = 1'b0, rx_raw = 1'b0, sig_valid = 1'b0;
  logic rx_en = 1'b0, blank_en = 1'b0, tv_mode = 1'b0, hes_free = 1'b0;
  logic rxd;
  int tests = 0, fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irrx_gate #(.CLK_HZ(T_HZ), .HOLD_NS(T_NS)) u_irrx_gate (
    .clk(clk), .rst(rst), .tick(tick), .led_on(led_on), .rx_raw(rx_raw),
    .sig_valid(sig_valid), .rx_en(rx_en), .blank_en(blank_en),
    .tv_mode(tv_mode), .hes_free(hes_free), .rxd(rxd));

  task automatic cyc();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, logic exp);
    tests++;
    if (rxd !== exp) begin
      fails++;
      $display("FAIL %s: rxd=%b expected %b at %0t", req, rxd, exp, $time);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    tv_mode = 1'b1; rx_en = 1'b1;
    repeat (3) cyc();
    chk("R1 in reset", 1'b1);
    rst = 1'b0;
    cyc(); chk("R1 first edge", 1'b1);
    repeat (3) cyc(); chk("R1 latch clear", 1'b1);

    // Sweep every blanking / mode / free-run combination
    for (int c = 0; c < 8; c++) begin
      logic be, tv, hs, wt;
      be = c[0]; tv = c[1]; hs = c[2]; wt = tv & ~hs;
      blank_en = be; tv_mode = tv; hes_free = hs;
      led_on = 0; sig_valid = 0; rx_raw = 0; rx_en = 0; tick = 1;
      cyc(); chk("R2 disabled", 1'b1);
      rx_en = 1;
      repeat (H + 2) cyc();
      chk(wt ? "R7 waiting" : "R9 immediate", wt ? 1'b1 : 1'b0);
      sig_valid = 1; cyc(); chk("R7 strobe passes", 1'b0);
      sig_valid = 0; cyc(); chk("R8 sticky", 1'b0);
      rx_raw = 1; cyc(); chk("R8 data one", 1'b1);
      rx_raw = 0; led_on = 1;
      repeat (3) cyc();
      chk(be ? "R3 blank" : "R6 no blank", be ? 1'b1 : 1'b0);
      led_on = 0;
      for (int k = 0; k < H; k++) begin
        cyc(); chk(be ? "R4 holdoff" : "R6 holdoff pass", be ? 1'b1 : 1'b0);
      end
      cyc(); chk("R4 release", 1'b0);
      rx_en = 0; cyc(); chk("R2 off", 1'b1);
      rx_en = 1; cyc(); chk(wt ? "R2 rearm R7" : "R9 reenable", wt ? 1'b1 : 1'b0);
    end

    // R10: bit pattern, one cycle latency
    blank_en = 1; tv_mode = 0; hes_free = 0; rx_en = 1; tick = 1;
    repeat (2) cyc();
    for (int b = 0; b < 8; b++) begin
      logic v;
      v = (8'b1011_0010 >> b) & 1'b1;
      rx_raw = v; cyc(); chk("R10 latency", v);
    end
    rx_raw = 0;

    // R5: restart during holdoff
    led_on = 1; cyc();
    led_on = 0;
    for (int k = 0; k < H - 2; k++) begin
      cyc(); chk("R5 first holdoff", 1'b1);
    end
    led_on = 1; cyc(); chk("R5 relit", 1'b1);
    led_on = 0;
    for (int k = 0; k < H; k++) begin
      cyc(); chk("R5 restarted holdoff", 1'b1);
    end
    cyc(); chk("R5 release", 1'b0);

    // R4: only ticks advance the holdoff
    led_on = 1; cyc();
    led_on = 0; tick = 0;
    repeat (10) cyc();
    chk("R4 no tick holds", 1'b1);
    for (int t = 0; t < H; t++) begin
      tick = 1; cyc();
      chk("R4 tick edge", 1'b1);
      tick = 0; cyc();
      chk("R4 after tick", (t == H - 1) ? 1'b0 : 1'b1);
    end
    tick = 1;

    // R6: blanking dropped mid-holdoff, then restored
    led_on = 1; cyc();
    led_on = 0;
    cyc(); cyc(); chk("R6 holdoff active", 1'b1);
    blank_en = 0; cyc(); chk("R6 unblanked pass", 1'b0);
    blank_en = 1; cyc(); chk("R6 reblank", 1'b1);
    repeat (H + 1) cyc();
    chk("R6 drained", 1'b0);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule